// File: doc/BRIEF.md
# Selectable Base Clock Divider

This block forms the base clock that a downstream clock generator halves into the system clocks. Two free-running clocks feed it. The first is an oscillator clock, which the block divides by two. The second is a VCO clock, which the block divides by three. A single select bit, written by software, chooses which divided clock drives the output. In both modes the output has an exact 50 percent duty cycle. For the odd ratio this comes from a counter phase clocked on the rising edge of the VCO clock, ORed with a copy of that phase retimed on the falling edge. Each level of the output then lasts one and a half VCO periods.

Changing the select bit starts a handshake between the two clock domains. The current source is gated off at an instant when its divided clock is low. The new source is gated on only after that, again at an instant when its own divided clock is low. This means no runt pulse reaches the output. A status output names the source that actually drives the output. It moves only when the new source has been enabled. Reset is asynchronous and active low. Reset clears every counter, holds the output low and leaves the oscillator path selected.

Top module: `cdiv_base_clk`

## Requirements
- R1: While rst_n is low, clk_base is 0 and src_vco is 0. After rst_n is released with sel_vco at 0, the first output pulses come from the oscillator path.
- R2: With the oscillator source active, clk_base has a period of two osc_clk periods. The high time and the low time each equal one osc_clk period.
- R3: With the VCO source active, clk_base has a period of three vco_clk periods. The high time and the low time each equal 1.5 vco_clk periods.
- R4: sel_vco = 0 requests the oscillator source and sel_vco = 1 requests the VCO source. After the switchover completes, the output runs at the ratio of the requested source.
- R5: During a switchover in either direction, clk_base shows no high pulse and no low pulse shorter than half the period of the faster input clock.
- R6: src_vco (0 = oscillator drives clk_base, 1 = VCO drives clk_base) keeps its old value right after sel_vco is changed. It takes the new value once the new source has been enabled.
- R7: Writing sel_vco with the value it already holds leaves clk_base high and low times and src_vco unchanged.
- R8: The two source gates are never open at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock, divided by two when selected |
| vco_clk | input | 1 | VCO clock, divided by three when selected |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_vco | input | 1 | Source select from the control register: 0 oscillator, 1 VCO |
| clk_base | output | 1 | Base clock output, 50 percent duty cycle |
| src_vco | output | 1 | Source actually driving clk_base: 0 oscillator, 1 VCO |

## Verification
The divider is observed in steady oscillator mode and in steady VCO mode. Each high time and each low time is measured against its own expected half-period, so an error in the rising-edge or falling-edge phase of the odd divider shows up as unequal levels rather than a wrong period. Rewrites of the current select value are placed just after a falling output edge, which separates a block that ignores them from one that restarts its handshake. Switchovers are requested at several phases relative to both input clocks, in both directions, with the shortest output pulse tracked across each one. The status flag is read both right after each write and after completion. A reset applied in the middle of VCO operation shows whether the block falls back to the oscillator path.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;

    // Default depth of the cross-domain enable synchronizers
    localparam int SYNC_STAGES_DEF = 2;

    // Encoding of the source flag
    typedef enum logic {
        SRC_OSC = 1'b0,
        SRC_VCO = 1'b1
    } src_e;

endpackage

// File: rtl/cdiv_even.sv
`timescale 1ns/1ps
// Even-ratio divider: the output toggles every DIV/2 input rising edges.
module cdiv_even #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic div_clk
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          out;
    } even_st_t;

    even_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt == CW'(HALF - 1)) begin
            s_d.cnt = '0;
            s_d.out = ~s_q.out;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign div_clk = s_q.out;

    // R2: the output changes level after every terminal count
    a_r2_half_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CW'(HALF - 1)) |=> (s_q.out != $past(s_q.out)));

endmodule

// File: rtl/cdiv_odd.sv
`timescale 1ns/1ps
// Odd-ratio divider with 50 percent duty: a rising-edge phase ORed with
// its copy retimed on the falling edge.
module cdiv_odd #(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic div_clk
);
    localparam int CW   = $clog2(DIV);
    localparam int HIGH = (DIV - 1) / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ph;
    } pos_st_t;

    typedef struct packed {
        logic ph;
    } neg_st_t;

    pos_st_t p_d, p_q;
    neg_st_t n_d, n_q;

    always_comb begin
        p_d = p_q;
        if (p_q.cnt == CW'(DIV - 1)) p_d.cnt = '0;
        else                         p_d.cnt = p_q.cnt + 1'b1;
        p_d.ph = (p_d.cnt < CW'(HIGH));
        n_d.ph = p_q.ph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) n_q <= '0;
        else        n_q <= n_d;
    end

    assign div_clk = p_q.ph | n_q.ph;

    // R3: when the retimed phase ends, the rising-edge phase is already low,
    // so the output gets its full low interval
    a_r3_low_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(n_q.ph) |-> !p_q.ph);

endmodule

// File: rtl/cdiv_gate.sv
`timescale 1ns/1ps
// Per-source enable: the request is synchronized on the source clock and
// the enable is updated on its falling edge only while the divided clock is low.
module cdiv_gate #(
    parameter int   STAGES = cdiv_pkg::SYNC_STAGES_DEF,
    parameter logic EN_RST = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic div_clk,
    output logic en
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
    } sync_st_t;

    typedef struct packed {
        logic en;
    } en_st_t;

    sync_st_t s_d, s_q;
    en_st_t   e_d, e_q;

    always_comb begin
        s_d.sync = {s_q.sync[STAGES-2:0], req};
        e_d      = e_q;
        if (!div_clk) e_d.en = s_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.sync <= {STAGES{EN_RST}};
        else        s_q <= s_d;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) e_q.en <= EN_RST;
        else        e_q <= e_d;
    end

    assign en = e_q.en;

    // R5: the gate never moves while its divided clock is high
    a_r5_en_hold_high: assert property (@(negedge clk) disable iff (!rst_n)
        div_clk |=> $stable(e_q.en));

endmodule

// File: rtl/cdiv_base_clk.sv
`timescale 1ns/1ps
module cdiv_base_clk #(
    parameter int OSC_DIV     = 2,
    parameter int VCO_DIV     = 3,
    parameter int SYNC_STAGES = cdiv_pkg::SYNC_STAGES_DEF
) (
    input  logic osc_clk,
    input  logic vco_clk,
    input  logic rst_n,
    input  logic sel_vco,
    output logic clk_base,
    output logic src_vco
);
    import cdiv_pkg::*;

    logic osc_div, vco_div;
    logic en_osc, en_vco;
    logic req_osc, req_vco;
    src_e src_cur;

    cdiv_even #(.DIV(OSC_DIV)) u_osc_div (
        .clk     (osc_clk),
        .rst_n   (rst_n),
        .div_clk (osc_div)
    );

    cdiv_odd #(.DIV(VCO_DIV)) u_vco_div (
        .clk     (vco_clk),
        .rst_n   (rst_n),
        .div_clk (vco_div)
    );

    // Each side asks for its gate only once the other gate is closed
    assign req_osc = ~sel_vco & ~en_vco;
    assign req_vco =  sel_vco & ~en_osc;

    cdiv_gate #(.STAGES(SYNC_STAGES), .EN_RST(1'b1)) u_osc_gate (
        .clk     (osc_clk),
        .rst_n   (rst_n),
        .req     (req_osc),
        .div_clk (osc_div),
        .en      (en_osc)
    );

    cdiv_gate #(.STAGES(SYNC_STAGES), .EN_RST(1'b0)) u_vco_gate (
        .clk     (vco_clk),
        .rst_n   (rst_n),
        .req     (req_vco),
        .div_clk (vco_div),
        .en      (en_vco)
    );

    assign clk_base = (osc_div & en_osc) | (vco_div & en_vco);

    // While both gates are closed, the old source is still reported
    always_comb begin
        if (en_vco)      src_cur = SRC_VCO;
        else if (en_osc) src_cur = SRC_OSC;
        else             src_cur = src_e'(~sel_vco);
    end

    assign src_vco = src_cur;

    // R8: the two gates are never open together
    always_comb begin
        if (rst_n) begin
            a_r8_single_source: assert (!(en_osc && en_vco))
                else $error("both source gates open");
        end
    end

endmodule

// File: tb/tb_cdiv_base_clk.sv
`timescale 1ns/1ps
module tb_cdiv_base_clk;

    logic osc_clk = 1'b0;
    logic vco_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic sel_vco = 1'b0;
    logic clk_base;
    logic src_vco;

    always #4 osc_clk = ~osc_clk;   // 125 MHz
    always #3 vco_clk = ~vco_clk;

    cdiv_base_clk dut (
        .osc_clk  (osc_clk),
        .vco_clk  (vco_clk),
        .rst_n    (rst_n),
        .sel_vco  (sel_vco),
        .clk_base (clk_base),
        .src_vco  (src_vco)
    );

    localparam real OSC_HALF = 8.0;
    localparam real VCO_HALF = 9.0;
    localparam real MIN_OK   = 3.0;

    typedef struct {
        bit      lvl;
        realtime w;
        string   tag;
    } item_t;

    item_t   exp_q[$];
    int      checks   = 0;
    int      failures = 0;
    bit      done     = 1'b0;
    bit      win_on   = 1'b0;
    realtime last_t   = 0.0;
    realtime min_w    = 1000.0;

    task automatic check_val(bit ok, string tag, string what, real act, real expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0.3f expected=%0.3f", tag, what, act, expv);
        end
    endtask

    // Monitor: measure each level of clk_base and compare with the queue
    always @(posedge clk_base or negedge clk_base) begin
        realtime now_t;
        realtime w;
        item_t   it;
        now_t  = $realtime;
        w      = now_t - last_t;
        last_t = now_t;
        if (rst_n) begin
            if (win_on && w < min_w) min_w = w;
            if (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                check_val((it.lvl == !clk_base) && (w > it.w - 0.01) && (w < it.w + 0.01),
                          it.tag, it.lvl ? "high time" : "low time", w, it.w);
            end
        end
    end

    // Driver: queue the expected levels starting with the next low level
    task automatic expect_pulses(real half, string tag, int pairs, bit rewrite);
        item_t it;
        @(negedge clk_base);
        #0.5;
        if (rewrite) sel_vco = sel_vco;
        for (int i = 0; i < pairs; i++) begin
            it.lvl = 1'b0; it.w = half; it.tag = tag; exp_q.push_back(it);
            it.lvl = 1'b1; it.w = half; it.tag = tag; exp_q.push_back(it);
        end
        for (int i = 0; i < 4000 && exp_q.size() > 0; i++) #1;
        if (exp_q.size() > 0) begin
            check_val(1'b0, tag, "pulses missing", real'(exp_q.size()), 0.0);
            exp_q.delete();
        end
    endtask

    task automatic do_switch(bit to_vco, real offset);
        bit old_src;
        old_src = src_vco;
        #offset;
        min_w  = 1000.0;
        win_on = 1'b1;
        sel_vco = to_vco;
        #0.5;
        check_val(src_vco == old_src, "R6", "flag right after write",
                  real'(src_vco), real'(old_src));
        for (int i = 0; i < 1000 && src_vco != to_vco; i++) #0.5;
        check_val(src_vco == to_vco, "R6", "flag after switchover",
                  real'(src_vco), real'(to_vco));
        expect_pulses(to_vco ? VCO_HALF : OSC_HALF, to_vco ? "R4 R3" : "R4 R2", 3, 1'b0);
        win_on = 1'b0;
        check_val(min_w >= MIN_OK, "R5", "shortest pulse in switchover", min_w, MIN_OK);
    endtask

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #20.3;
        check_val(clk_base == 1'b0, "R1", "clk_base in reset", real'(clk_base), 0.0);
        check_val(src_vco == 1'b0, "R1", "src_vco in reset", real'(src_vco), 0.0);
        #30.0;
        rst_n = 1'b1;
        #1.0;
        check_val(clk_base == 1'b0, "R1", "clk_base after release", real'(clk_base), 0.0);
        check_val(src_vco == 1'b0, "R1", "src_vco after release", real'(src_vco), 0.0);

        // R2: steady oscillator mode
        expect_pulses(OSC_HALF, "R1 R2", 4, 1'b0);

        // R7: rewrite of the current value in oscillator mode
        expect_pulses(OSC_HALF, "R7", 4, 1'b1);
        check_val(src_vco == 1'b0, "R7", "flag after rewrite", real'(src_vco), 0.0);

        // Switchovers at several phases of both clocks
        do_switch(1'b1, 0.3);
        expect_pulses(VCO_HALF, "R3", 4, 1'b0);
        expect_pulses(VCO_HALF, "R7", 4, 1'b1);
        check_val(src_vco == 1'b1, "R7", "flag after rewrite", real'(src_vco), 1.0);
        do_switch(1'b0, 1.3);
        do_switch(1'b1, 2.7);
        do_switch(1'b0, 3.9);
        do_switch(1'b1, 5.1);

        // R1: reset during VCO operation falls back to the oscillator
        sel_vco = 1'b0;
        #0.2;
        rst_n = 1'b0;
        #5.0;
        check_val(clk_base == 1'b0, "R1", "clk_base in second reset", real'(clk_base), 0.0);
        check_val(src_vco == 1'b0, "R1", "src_vco in second reset", real'(src_vco), 0.0);
        #20.1;
        rst_n = 1'b1;
        expect_pulses(OSC_HALF, "R1", 3, 1'b0);
        check_val(src_vco == 1'b0, "R1", "src_vco after second reset", real'(src_vco), 0.0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule